// File: doc/BRIEF.md
# Instruction Exception Source Classifier

This block sits beside the decode and execute stages of a simple in-order core. It inspects the class flags of the instruction being issued, whether that instruction occupies a delayed-branch slot, the integer divide operands, and a register-bank occupancy counter that it keeps itself. From these inputs it raises at most one exception request per cycle, together with a 3-bit cause code.

An instruction is only taken into account on a cycle where it is presented (`issue_vld`) and the previous instruction has completed (`prev_done`). Bank-using interrupts that the core accepts fill the register bank, and bank-restore instructions drain it. An interrupt that arrives while the bank is full raises a bank overflow exception if overflow reporting is enabled. If several sources are active together, a fixed priority picks the one that is reported.

Cause codes: 0 none, 1 slot illegal, 2 general illegal, 3 bank underflow, 4 bank overflow, 5 trap, 6 divide by zero, 7 signed divide overflow. With the default `REG_OUT=1`, the request and cause are registered. They appear in the cycle after the qualifying input cycle and last for exactly one cycle.

Top module: `iexc_classifier`

## Requirements
- R1: An accepted instruction with `ins_undef`=1 and `in_slot`=0 raises cause 2 (general illegal).
- R2: An accepted instruction with `ins_undef`=1 and `in_slot`=1 raises cause 1 (slot illegal), never cause 2.
- R3: With `in_slot`=1, an accepted instruction flagged `ins_pc_write`, `ins_wide`, `ins_restore`, `ins_div_s`, `ins_div_u` or `ins_trap` raises cause 1. Outside a slot, `ins_pc_write` or `ins_wide` alone raises nothing.
- R4: Outside a slot, an accepted `ins_div_s` or `ins_div_u` with a divisor of zero raises cause 6.
- R5: Outside a slot, an accepted `ins_div_s` whose dividend is the most negative value (only the MSB set) and whose divisor is all ones raises cause 7. `ins_div_u` with the same operands raises nothing, and so does `ins_div_s` with ordinary operands.
- R6: An accepted `ins_restore` outside a slot while the bank count is 0 raises cause 3 and leaves the count at 0. With a non-zero count it raises nothing and decrements the count. A restore that is rejected as slot illegal does not change the count.
- R7: `irq_bank_acc` while the count is below `BANK_DEPTH` increments the count and raises nothing. While the count equals `BANK_DEPTH`, it raises cause 4 only if `ovf_en`=1, and the count stays at `BANK_DEPTH` in either case.
- R8: An accepted `ins_trap` outside a slot raises cause 5.
- R9: If sources coincide, the reported cause follows the order slot illegal, general illegal, bank (underflow or overflow), trap, division.
- R10: No instruction-related exception is raised unless `issue_vld` and `prev_done` are both 1 in that cycle. With `irq_bank_acc` also 0, `exc_req` stays 0.
- R11: `exc_req` and `exc_cause` are registered. They are valid for one cycle, in the cycle after the input cycle, and `exc_cause` is 0 whenever `exc_req` is 0. After reset both are 0 and the bank count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction is presented at decode |
| prev_done | input | 1 | The previous instruction has completed |
| in_slot | input | 1 | The instruction sits in a delayed-branch slot |
| ins_undef | input | 1 | Undefined opcode |
| ins_pc_write | input | 1 | Instruction rewrites the PC |
| ins_wide | input | 1 | 32-bit instruction |
| ins_restore | input | 1 | Register-bank restore instruction |
| ins_div_s | input | 1 | Signed integer divide |
| ins_div_u | input | 1 | Unsigned integer divide |
| ins_trap | input | 1 | Trap instruction |
| div_dividend | input | DATA_W | Divide dividend |
| div_divisor | input | DATA_W | Divide divisor |
| ovf_en | input | 1 | Enables the bank overflow exception |
| irq_bank_acc | input | 1 | A bank-using interrupt was accepted |
| exc_req | output | 1 | Exception request strobe |
| exc_cause | output | 3 | Encoded exception cause |

## Verification
The bench builds the block with `DATA_W=16` and `BANK_DEPTH=3`. The narrow data width makes the most-negative-by-minus-one case a 16-bit pattern that is easy to read, and the signed/unsigned distinction is checked at that width. The shallow bank lets a few interrupts reach the full state. From there the bench can check saturation with overflow reporting on and off, drain the bank by counting restores until the underflow appears, and check that bank overflow takes priority over a trap in the same cycle.

// File: rtl/iexc_pkg.sv
package iexc_pkg;

   localparam int CAUSE_W = 3;
   localparam int NUM_SRC = 7;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_SLOT  = 3'd1,
      CAUSE_GEN   = 3'd2,
      CAUSE_BUNF  = 3'd3,
      CAUSE_BOVF  = 3'd4,
      CAUSE_TRAP  = 3'd5,
      CAUSE_DZERO = 3'd6,
      CAUSE_DOVF  = 3'd7
   } cause_e;

   typedef struct packed {
      logic undef;
      logic pc_write;
      logic wide;
      logic restore;
      logic div_s;
      logic div_u;
      logic trap;
   } ins_flags_t;

endpackage

// File: rtl/iexc_bank_track.sv
module iexc_bank_track #(
   parameter int BANK_DEPTH = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restore_go,
   input  logic irq_acc,
   input  logic ovf_en,
   output logic empty,
   output logic full,
   output logic ovf_hit
);
   localparam int CNT_W = $clog2(BANK_DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BANK_DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             inc;
   logic             dec;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_MAX);
   assign inc     = irq_acc & ~full;
   assign dec     = restore_go & ~empty;
   assign ovf_hit = irq_acc & full & ovf_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/iexc_div_check.sv
module iexc_div_check #(
   parameter int DATA_W = 32
) (
   input  logic              div_s,
   input  logic              div_u,
   input  logic [DATA_W-1:0] dividend,
   input  logic [DATA_W-1:0] divisor,
   output logic              zero,
   output logic              ovf
);
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] MINUS_1  = {DATA_W{1'b1}};

   logic divisor_zero;

   assign divisor_zero = (divisor == '0);
   assign zero         = (div_s | div_u) & divisor_zero;
   assign ovf          = div_s & ~divisor_zero &
                         (dividend == MOST_NEG) & (divisor == MINUS_1);
endmodule

// File: rtl/iexc_prio.sv
module iexc_prio
   import iexc_pkg::*;
#(
   parameter int N_SRC = NUM_SRC
) (
   input  logic [N_SRC-1:0]   hits,
   output logic               any,
   output logic [CAUSE_W-1:0] cause
);
   // hits[0] is the highest priority; source index i reports cause i+1
   always_comb begin
      cause = CAUSE_NONE;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (hits[i]) cause = CAUSE_W'(i + 1);
      end
   end
   assign any = |hits;
endmodule

// File: rtl/iexc_classifier.sv
module iexc_classifier
   import iexc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int BANK_DEPTH = 15,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_vld,
   input  logic               prev_done,
   input  logic               in_slot,
   input  logic               ins_undef,
   input  logic               ins_pc_write,
   input  logic               ins_wide,
   input  logic               ins_restore,
   input  logic               ins_div_s,
   input  logic               ins_div_u,
   input  logic               ins_trap,
   input  logic [DATA_W-1:0]  div_dividend,
   input  logic [DATA_W-1:0]  div_divisor,
   input  logic               ovf_en,
   input  logic               irq_bank_acc,
   output logic               exc_req,
   output logic [CAUSE_W-1:0] exc_cause
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (BANK_DEPTH < 1) begin : g_bad_depth
         $error("BANK_DEPTH must be at least 1");
      end
   endgenerate

   ins_flags_t fl;
   assign fl = '{undef: ins_undef, pc_write: ins_pc_write, wide: ins_wide,
                 restore: ins_restore, div_s: ins_div_s, div_u: ins_div_u,
                 trap: ins_trap};

   logic accept;
   logic legal;
   logic slot_hit;
   logic gen_hit;
   logic restore_go;
   logic bank_empty;
   logic bank_full;
   logic bank_ovf;
   logic div_zero;
   logic div_ovf;
   logic [NUM_SRC-1:0] hits;
   logic               any_c;
   logic [CAUSE_W-1:0] cause_c;

   assign accept     = issue_vld & prev_done;
   assign slot_hit   = accept & in_slot &
                       (fl.undef | fl.pc_write | fl.wide | fl.restore |
                        fl.div_s | fl.div_u | fl.trap);
   assign gen_hit    = accept & ~in_slot & fl.undef;
   assign legal      = accept & ~in_slot & ~fl.undef;
   assign restore_go = legal & fl.restore;

   iexc_bank_track #(.BANK_DEPTH(BANK_DEPTH)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .restore_go (restore_go),
      .irq_acc    (irq_bank_acc),
      .ovf_en     (ovf_en),
      .empty      (bank_empty),
      .full       (bank_full),
      .ovf_hit    (bank_ovf)
   );

   iexc_div_check #(.DATA_W(DATA_W)) u_div (
      .div_s    (fl.div_s),
      .div_u    (fl.div_u),
      .dividend (div_dividend),
      .divisor  (div_divisor),
      .zero     (div_zero),
      .ovf      (div_ovf)
   );

   // index order is the priority order
   assign hits[0] = slot_hit;
   assign hits[1] = gen_hit;
   assign hits[2] = restore_go & bank_empty;
   assign hits[3] = bank_ovf;
   assign hits[4] = legal & fl.trap;
   assign hits[5] = legal & div_zero;
   assign hits[6] = legal & div_ovf;

   iexc_prio #(.N_SRC(NUM_SRC)) u_prio (
      .hits  (hits),
      .any   (any_c),
      .cause (cause_c)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exc_req   <= 1'b0;
               exc_cause <= CAUSE_NONE;
            end else begin
               exc_req   <= any_c;
               exc_cause <= cause_c;
            end
         end
      end else begin : g_comb_out
         logic unused_full;
         assign unused_full = bank_full;
         always_comb begin
            exc_req   = any_c;
            exc_cause = cause_c;
         end
      end
   endgenerate
endmodule

// File: rtl/iexc_classifier_chk.sv
module iexc_classifier_chk #(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_vld,
   input logic              prev_done,
   input logic              in_slot,
   input logic              ins_undef,
   input logic              ins_pc_write,
   input logic              ins_wide,
   input logic              ins_restore,
   input logic              ins_div_s,
   input logic              ins_div_u,
   input logic              ins_trap,
   input logic [DATA_W-1:0] div_divisor,
   input logic              ovf_en,
   input logic              irq_bank_acc,
   input logic              exc_req,
   input logic [2:0]        exc_cause
);
   logic acc;
   assign acc = issue_vld & prev_done;

   generate
      if (REG_OUT) begin : g_chk
         AST_GEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            acc && !in_slot && ins_undef |=> exc_req && exc_cause == 3'd2); // R1
         AST_SLOT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
            acc && in_slot && ins_undef |=> exc_req && exc_cause == 3'd1); // R2
         AST_SLOT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
            acc && in_slot && (ins_pc_write || ins_wide || ins_restore ||
                               ins_div_s || ins_div_u || ins_trap)
            |=> exc_req && exc_cause == 3'd1); // R3
         AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            acc && !in_slot && !ins_undef && !ins_restore && !ins_trap &&
            !irq_bank_acc && (ins_div_s || ins_div_u) && div_divisor == '0
            |=> exc_req && exc_cause == 3'd6); // R4
         AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            exc_req && exc_cause == 3'd4 |-> $past(irq_bank_acc && ovf_en)); // R7
         AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !acc && !irq_bank_acc |=> !exc_req); // R10
      end
   endgenerate
endmodule

bind iexc_classifier iexc_classifier_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_vld    (issue_vld),
   .prev_done    (prev_done),
   .in_slot      (in_slot),
   .ins_undef    (ins_undef),
   .ins_pc_write (ins_pc_write),
   .ins_wide     (ins_wide),
   .ins_restore  (ins_restore),
   .ins_div_s    (ins_div_s),
   .ins_div_u    (ins_div_u),
   .ins_trap     (ins_trap),
   .div_divisor  (div_divisor),
   .ovf_en       (ovf_en),
   .irq_bank_acc (irq_bank_acc),
   .exc_req      (exc_req),
   .exc_cause    (exc_cause)
);

// File: tb/tb_iexc_classifier.sv
`timescale 1ns/1ps
module tb_iexc_classifier;
   localparam int DW = 16;
   localparam int BD = 3;

   // flag bit positions: {trap, div_u, div_s, restore, wide, pc_write, undef}
   localparam logic [6:0] F_UNDEF = 7'h01;
   localparam logic [6:0] F_PCW   = 7'h02;
   localparam logic [6:0] F_WIDE  = 7'h04;
   localparam logic [6:0] F_REST  = 7'h08;
   localparam logic [6:0] F_DIVS  = 7'h10;
   localparam logic [6:0] F_DIVU  = 7'h20;
   localparam logic [6:0] F_TRAP  = 7'h40;

   logic clk = 1'b0;
   logic rst_n;
   logic issue_vld, prev_done, in_slot, ovf_en, irq_bank_acc;
   logic [6:0] flags;
   logic [DW-1:0] dvd, dvs;
   logic exc_req;
   logic [2:0] exc_cause;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   iexc_classifier #(.DATA_W(DW), .BANK_DEPTH(BD), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .prev_done(prev_done),
      .in_slot(in_slot), .ins_undef(flags[0]), .ins_pc_write(flags[1]),
      .ins_wide(flags[2]), .ins_restore(flags[3]), .ins_div_s(flags[4]),
      .ins_div_u(flags[5]), .ins_trap(flags[6]), .div_dividend(dvd),
      .div_divisor(dvs), .ovf_en(ovf_en), .irq_bank_acc(irq_bank_acc),
      .exc_req(exc_req), .exc_cause(exc_cause));

   task automatic idle();
      issue_vld = 0; prev_done = 1; in_slot = 0; flags = '0;
      dvd = 16'd7; dvs = 16'd2; ovf_en = 0; irq_bank_acc = 0;
   endtask

   task automatic expect_out(input logic [2:0] exp, input string tag);
      n_chk++;
      if (exc_req !== (exp != 3'd0) || exc_cause !== exp) begin
         n_bad++;
         $display("FAIL %s: req=%b cause=%0d expected req=%b cause=%0d",
                  tag, exc_req, exc_cause, (exp != 3'd0), exp);
      end
   endtask

   // one instruction/interrupt cycle, checked in the following cycle
   task automatic run(input logic [6:0] f, input logic slot, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic iv, input logic pd,
                      input logic irq, input logic oen, input logic [2:0] exp,
                      input string tag);
      @(negedge clk);
      issue_vld = iv; prev_done = pd; in_slot = slot; flags = f;
      dvd = a; dvs = b; irq_bank_acc = irq; ovf_en = oen;
      @(negedge clk);
      expect_out(exp, tag);
      idle();
   endtask

   task automatic ins(input logic [6:0] f, input logic slot, input logic [2:0] exp,
                      input string tag);
      run(f, slot, 16'd9, 16'd3, 1, 1, 0, 0, exp, tag);
   endtask

   task automatic irq(input logic oen, input logic [2:0] exp, input string tag);
      run('0, 0, 16'd9, 16'd3, 0, 1, 1, oen, exp, tag);
   endtask

   task automatic t_reset();
      expect_out(3'd0, "R11 reset state");
      ins(F_REST, 0, 3'd3, "R11 bank empty after reset");
   endtask

   task automatic t_illegal();
      ins(F_UNDEF, 0, 3'd2, "R1 general illegal");
      ins(F_UNDEF, 1, 3'd1, "R2 slot undefined");
      ins(F_PCW, 1, 3'd1, "R3 slot pc write");
      ins(F_WIDE, 1, 3'd1, "R3 slot wide");
      ins(F_REST, 1, 3'd1, "R3 slot restore");
      ins(F_DIVS, 1, 3'd1, "R3 slot divs");
      ins(F_DIVU, 1, 3'd1, "R3 slot divu");
      ins(F_TRAP, 1, 3'd1, "R3 slot trap");
      ins(F_PCW, 0, 3'd0, "R3 pc write outside slot");
      ins(F_WIDE, 0, 3'd0, "R3 wide outside slot");
   endtask

   task automatic t_div();
      run(F_DIVU, 0, 16'd5, 16'd0, 1, 1, 0, 0, 3'd6, "R4 divu by zero");
      run(F_DIVS, 0, 16'h8000, 16'd0, 1, 1, 0, 0, 3'd6, "R4 divs by zero");
      run(F_DIVS, 0, 16'h8000, 16'hFFFF, 1, 1, 0, 0, 3'd7, "R5 divs overflow");
      run(F_DIVU, 0, 16'h8000, 16'hFFFF, 1, 1, 0, 0, 3'd0, "R5 divu same operands");
      run(F_DIVS, 0, 16'h8001, 16'hFFFF, 1, 1, 0, 0, 3'd0, "R5 divs ordinary");
   endtask

   task automatic t_trap_gate();
      ins(F_TRAP, 0, 3'd5, "R8 trap");
      run(F_UNDEF, 0, 16'd1, 16'd1, 1, 0, 0, 0, 3'd0, "R10 prev not done");
      run(F_TRAP, 0, 16'd1, 16'd1, 0, 1, 0, 0, 3'd0, "R10 no issue");
      ins(F_UNDEF, 0, 3'd2, "R10 prev done");
      @(negedge clk);
      expect_out(3'd0, "R11 single cycle strobe");
   endtask

   task automatic t_bank();
      for (int i = 0; i < BD; i++) irq(1, 3'd0, "R7 fill bank");
      for (int i = 0; i < BD; i++) ins(F_REST, 0, 3'd0, "R6 restore with count");
      ins(F_REST, 0, 3'd3, "R6 underflow after drain");
      ins(F_REST, 0, 3'd3, "R6 count held at zero");
      irq(0, 3'd0, "R7 one saved");
      ins(F_REST, 1, 3'd1, "R6 slot restore rejected");
      ins(F_REST, 0, 3'd0, "R6 count not touched by slot restore");
      ins(F_REST, 0, 3'd3, "R6 underflow after single");
      for (int i = 0; i < BD + 2; i++) irq(0, 3'd0, "R7 no overflow when disabled");
      for (int i = 0; i < BD; i++) ins(F_REST, 0, 3'd0, "R7 saturated drain");
      ins(F_REST, 0, 3'd3, "R7 saturated at depth");
      for (int i = 0; i < BD; i++) irq(1, 3'd0, "R7 refill");
      irq(1, 3'd4, "R7 overflow enabled");
      run(F_TRAP, 0, 16'd1, 16'd1, 1, 1, 1, 1, 3'd4, "R9 bank overflow over trap");
      for (int i = 0; i < BD; i++) ins(F_REST, 0, 3'd0, "R7 full count kept");
      ins(F_REST, 0, 3'd3, "R7 drained after overflow");
   endtask

   task automatic t_prio();
      ins(F_UNDEF | F_TRAP, 1, 3'd1, "R9 slot over rest");
      ins(F_UNDEF | F_TRAP, 0, 3'd2, "R9 general over trap");
      run(F_REST | F_DIVU, 0, 16'd1, 16'd0, 1, 1, 0, 0, 3'd3, "R9 underflow over div");
      run(F_TRAP | F_DIVU, 0, 16'd1, 16'd0, 1, 1, 0, 0, 3'd5, "R9 trap over div");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_illegal();
      t_div();
      t_trap_gate();
      t_bank();
      t_prio();
      summary();
   end
endmodule